// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts video scanlines down from a programmed start value and raises a level interrupt request toward the CPU when the count lands on zero. Software programs it through four write locations. One sets the start value, one asks for a reload, one switches the interrupt off and clears a pending request, and one switches it on. A one-cycle scanline tick comes from a line-edge detector elsewhere in the controller. This block does not look at video address traffic.

The block sits inside a multi-personality cartridge controller. An activity input is high only while the controller runs the personality that owns this counter. While that input is low, ticks and register writes are both ignored and all state is held. Each tick first reloads the counter from the start value or decrements it. It then checks the new count. A zero count with the interrupt switched on sets the request, and the request stays set until software switches the interrupt off.

Top module: `scanline_irq_counter`

## Requirements
- R1: After a synchronous active-low reset, `irq_out` is 0 and the counter, start value, reload flag and enable flag are all zero. Enabling the interrupt and giving one tick then raises `irq_out`.
- R2: A write is decoded from `wr_addr & 16'hE001` only. The four locations are 0xC000, 0xC001, 0xE000 and 0xE001, so every address with the same masked value (for example 0xDFFE, 0xC7F1, 0xFFFF, 0xFFFE) acts the same. Any other masked value, such as 0x8000, 0x8001 or 0xA000, has no effect.
- R3: A write at masked 0xC000 stores `wr_data` as the start value. A write at masked 0xC001 sets the reload flag, whatever the data.
- R4: On a tick, if the counter is zero or the reload flag is set, the counter takes the start value and the reload flag clears. Otherwise the counter decreases by one. After a start value N is armed with a reload, the count reaches zero on tick N+1, or on tick 1 when N is 0.
- R5: After the tick step, if the counter is zero and the enable flag is set, `irq_out` goes to 1 in the next cycle. This includes a reload to a start value of zero.
- R6: A write at masked 0xE000 clears the enable flag and drops `irq_out`. A write at masked 0xE001 sets the enable flag. While the enable flag is clear, ticks never raise `irq_out`.
- R7: Once set, `irq_out` stays 1 through later ticks until a write at masked 0xE000 or a reset.
- R8: While `pers_active` is 0, ticks and writes have no effect on any state. `irq_out` does not rise.
- R9: When a write and a tick arrive in the same cycle, the write takes effect first. The tick step then uses the updated start value, reload flag and enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pers_active | input | 1 | High while the owning personality is selected; gates ticks and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| line_tick | input | 1 | One-cycle scanline pulse |
| irq_out | output | 1 | Level interrupt request |

## Verification
The bench sweeps every 8-bit start value. For each one it checks that the request stays low for exactly N ticks after a reload and rises on tick N+1. A counter that decremented on the reload tick, or wrapped instead of reloading at zero, would be off by one or would never fire. It also checks that a later tick leaves the request set, which catches a design that recomputed the level on every tick.

Same-cycle write-and-tick cases are checked for all three kinds of write: reload, start value and enable. A design that applied the tick before the write would fire a line late, load the stale start value, or miss the request. Mirror addresses and unmapped addresses are written, and writes and ticks are given while the personality is inactive. This catches sloppy decoding, and also a design that let stray ticks or writes through and so fires early or not at all.

// File: rtl/scanirq_pkg.sv
// Shared constants and types for the scanline interrupt counter.
// Assumes a 16-bit CPU write address; only the bits in DEC_MASK are decoded.
package scanirq_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned N_SEL  = 4;

    localparam logic [ADDR_W-1:0] DEC_MASK = 16'hE001;

    // Order of the select vector produced by the decoder
    typedef enum logic [1:0] {
        SEL_START  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_OFF    = 2'd2,
        SEL_ON     = 2'd3
    } reg_sel_e;

    // Masked address matched by each select
    localparam logic [ADDR_W-1:0] SEL_MATCH [N_SEL] = '{
        16'hC000, 16'hC001, 16'hE000, 16'hE001
    };

    typedef struct packed {
        logic start_wr;
        logic reload_wr;
        logic irq_off;
        logic irq_on;
    } wr_strobe_t;

endpackage

// File: rtl/scanirq_decode.sv
// Write decoder: turns an accepted bus write into one strobe per location.
// Assumes wr_en is a single-cycle strobe. Writes are dropped while the
// owning personality is inactive.
module scanirq_decode
    import scanirq_pkg::*;
(
    input  logic              wr_en,
    input  logic              accept,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_strobe_t        strobe
);

    logic [N_SEL-1:0] hit;
    logic [ADDR_W-1:0] masked;

    // Keep only the decoded address bits
    assign masked = wr_addr & DEC_MASK;

    // One comparator per register location
    for (genvar i = 0; i < N_SEL; i++) begin : g_sel
        assign hit[i] = wr_en & accept & (masked == SEL_MATCH[i]);
    end

    // Map the select vector onto named strobes
    always_comb begin
        strobe.start_wr  = hit[SEL_START];
        strobe.reload_wr = hit[SEL_RELOAD];
        strobe.irq_off   = hit[SEL_OFF];
        strobe.irq_on    = hit[SEL_ON];
    end

endmodule

// File: rtl/scanirq_count.sv
// Down-counter with start-value register and reload flag.
// Assumes tick is already gated by personality. A write in the same cycle
// as a tick is forwarded so the tick step sees the new value.
module scanirq_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_wr,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] start_q, start_eff, cnt_q, cnt_d;
    logic             reload_q, reload_eff, reload_d, do_load;

    // Forward this cycle's writes ahead of the tick step
    always_comb begin
        start_eff  = start_wr ? wr_data : start_q;
        reload_eff = reload_q | reload_wr;
        do_load    = (cnt_q == '0) | reload_eff;
    end

    // Tick step: reload or decrement
    always_comb begin
        cnt_d    = cnt_q;
        reload_d = reload_eff;
        if (tick) begin
            if (do_load) begin
                cnt_d    = start_eff;
                reload_d = 1'b0;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    // Zero reached as a result of this tick
    assign zero_evt = tick & (cnt_d == '0);

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            cnt_q    <= '0;
            reload_q <= 1'b0;
        end else begin
            start_q  <= start_eff;
            cnt_q    <= cnt_d;
            reload_q <= reload_d;
        end
    end

    p_start_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> start_q == $past(wr_data));

    p_reload_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_q == '0 || reload_q || reload_wr)) |=>
            (cnt_q == $past(start_eff)) && !reload_q);

    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0 && !reload_q && !reload_wr) |=>
            cnt_q == $past(cnt_q) - ONE);

    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/scanirq_flag.sv
// Enable flag and sticky interrupt request.
// Assumes off and on strobes are never both high. Enable updates before
// the zero event is qualified.
module scanirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_evt,
    input  logic irq_off,
    input  logic irq_on,
    output logic irq_q
);

    logic en_q, en_d, irq_d;

    // Enable after this cycle's writes
    always_comb begin
        en_d = en_q;
        if (irq_off)     en_d = 1'b0;
        else if (irq_on) en_d = 1'b1;
    end

    // Request: cleared by the off write, else set by an enabled zero
    always_comb begin
        if (irq_off) irq_d = 1'b0;
        else         irq_d = irq_q | (zero_evt & en_d);
    end

    // Flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            irq_q <= irq_d;
        end
    end

    p_off_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_off |=> !irq_q && !en_q);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_off) |=> irq_q);

    p_rise_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> en_q);

endmodule

// File: rtl/scanline_irq_counter.sv
// Top of the scanline interrupt counter. Decodes register writes, runs
// the down-counter and holds the sticky request. Assumes line_tick comes
// from an external line-edge detector and pers_active is high only while
// the owning personality is selected.
module scanline_irq_counter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pers_active,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_tick,
    output logic              irq_out
);

    import scanirq_pkg::*;

    localparam int unsigned CNT_W = DATA_W;

    wr_strobe_t strobe;
    logic       tick_g, zero_evt;

    // Ticks only count while this personality owns the controller
    assign tick_g = line_tick & pers_active;

    scanirq_decode u_dec (
        .wr_en   (wr_en),
        .accept  (pers_active),
        .wr_addr (wr_addr),
        .strobe  (strobe)
    );

    scanirq_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_g),
        .start_wr  (strobe.start_wr),
        .reload_wr (strobe.reload_wr),
        .wr_data   (wr_data),
        .zero_evt  (zero_evt)
    );

    scanirq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_evt (zero_evt),
        .irq_off  (strobe.irq_off),
        .irq_on   (strobe.irq_on),
        .irq_q    (irq_out)
    );

    p_quiet_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pers_active && !irq_out) |=> !irq_out);

    p_rise_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(line_tick && pers_active));

endmodule

// File: tb/sim_scanline_irq_counter.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps all start values and probes write/tick corners.
module sim_scanline_irq_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pers_active = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_tick = 1'b0;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    scanline_irq_counter u0 (
        .clk(clk), .rst_n(rst_n), .pers_active(pers_active),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .line_tick(line_tick), .irq_out(irq_out)
    );

    task automatic chk(input logic exp, input string tag);
        n_cmp++;
        if (irq_out !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_out actual %b expected %b", tag, irq_out, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk); line_tick = 1'b1;
        @(negedge clk); line_tick = 1'b0;
    endtask

    task automatic wr_tk(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; line_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; line_tick = 1'b0;
    endtask

    // Arm start value n with reload and interrupt enabled
    task automatic arm(input logic [7:0] n);
        wr(16'hE000, 8'h00);
        wr(16'hC000, n);
        wr(16'hC001, 8'h00);
        wr(16'hE001, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b0, "R1 reset level");
        wr(16'hE001, 8'h00);
        chk(1'b0, "R1 enable alone");
        tk();
        chk(1'b1, "R1 zero count and zero start fire");

        // R6: off write drops the request; disabled ticks stay quiet
        wr(16'hE000, 8'h00);
        chk(1'b0, "R6 off write clears");
        for (int k = 0; k < 3; k++) begin
            tk();
            chk(1'b0, "R6 disabled ticks");
        end

        // R3/R4/R5/R7: every start value fires on tick N+1 (tick 1 for zero)
        for (int n = 0; n < 256; n++) begin
            arm(8'(n));
            chk(1'b0, "R4 armed quiet");
            for (int k = 0; k < n; k++) begin
                tk();
                chk(1'b0, "R4 before zero");
            end
            tk();
            chk(1'b1, "R5 fire at zero");
            tk();
            chk(1'b1, "R7 sticky over tick");
        end

        // R2: mirror addresses and unmapped addresses
        wr(16'hFFFE, 8'h55);
        chk(1'b0, "R2 mirror off");
        wr(16'hDFFE, 8'd3);
        wr(16'hC7F1, 8'h00);
        wr(16'hFFFF, 8'h00);
        wr(16'h8000, 8'd0);
        wr(16'h8001, 8'd0);
        wr(16'hA000, 8'd0);
        wr(16'hBFFE, 8'd0);
        for (int k = 0; k < 3; k++) begin
            tk();
            chk(1'b0, "R2 mirror start 3 quiet");
        end
        tk();
        chk(1'b1, "R2 mirror start 3 fires");

        // R8: inactive personality drops ticks and writes
        arm(8'd2);
        pers_active = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tk();
            chk(1'b0, "R8 inactive ticks");
        end
        wr(16'hE000, 8'h00);
        wr(16'hC000, 8'd9);
        pers_active = 1'b1;
        tk(); chk(1'b0, "R8 resume tick1");
        tk(); chk(1'b0, "R8 resume tick2");
        tk(); chk(1'b1, "R8 state kept, fires tick3");

        // R9a: reload write with tick reloads this tick
        arm(8'd5);
        tk();
        wr_tk(16'hC001, 8'h00);
        for (int k = 0; k < 4; k++) begin
            tk();
            chk(1'b0, "R9 reload+tick quiet");
        end
        tk();
        chk(1'b1, "R9 reload+tick fires after 5");

        // R9b: start write with tick at zero loads the new value
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);
        wr_tk(16'hC000, 8'd0);
        chk(1'b1, "R9 start+tick loads new zero");

        // R9c: enable write with tick reaching zero fires
        wr(16'hE000, 8'h00);
        wr(16'hC000, 8'd1);
        wr(16'hC001, 8'h00);
        tk();
        chk(1'b0, "R9 disabled load");
        wr_tk(16'hE001, 8'h00);
        chk(1'b1, "R9 enable+tick fires");

        // R1: reset clears the request
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(1'b0, "R1 reset drops request");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule